// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block turns interrupt requests on a set of input lines into message-signalled writes. Each pin owns a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination, the destination mode, the trigger mode and a mask. The block keeps a pending bit for every pin. It scans the pins that are pending and unmasked, lowest number first, and presents one message per cycle on a valid/ready port. Each message is an address word and a data word.

Edge-triggered pins latch a rising request and drop the pending bit once the message is issued. Level-triggered pins follow the line and lock their entry with a remote-pending flag after a delivery. That flag is released only by an end-of-interrupt broadcast that carries the entry's vector, and the pin is delivered again if its line is still high. Legacy input line 0 is steered onto pin 2.

The entries are written and read through a 32-bit half-word port. The remote-pending flag is read-only at that port.

Top module: `irq_route_engine`

## Requirements
- R1: After reset no message is valid, and every entry half reads as zero.
- R2: A request on line 0 is delivered through pin 2's entry. Pin 0 never becomes pending from any line. Lines other than 0 map one to one onto pins, and line 2 also drives pin 2.
- R3: A level-triggered pin is pending exactly while its line is high. If the line falls before the pin is picked, no message is sent.
- R4: A rising request on an edge-triggered pin whose mask (entry bit 16) is set is discarded. Clearing the mask later sends nothing for it.
- R5: Among pending, unmasked pins, the lowest pin number is issued first.
- R6: An edge-triggered pin (entry bit 15 = 0) sends exactly one message per rising request, and its pending bit clears when that message is issued.
- R7: Issuing a level-triggered pin (entry bit 15 = 1) sets its remote-pending bit (entry bit 14). While that bit is set the pin is not issued again.
- R8: An end-of-interrupt with vector V clears remote-pending in every entry whose vector (bits 7:0) equals V. A pin whose line is still high and whose entry is unmasked is then issued again. Any other vector changes nothing.
- R9: Message address = 0xFEE00000 | destination (entry bits 63:48) shifted left by 4 | destination mode (entry bit 11) shifted left by 2. Message data = vector in bits 7:0, delivery mode (entry bits 10:8) in bits 10:8, trigger mode in bit 15.
- R10: While the message is valid and not ready, the address and data hold. At most one pin is issued per cycle.
- R11: Writes cannot change remote-pending, and reserved bits (12 and 47:17) read as zero. Writing an entry with trigger mode set to edge clears its remote-pending bit. Rewriting an entry so that it becomes unmasked issues a pin that is already pending.
- R12: Entry indices at or above the pin count read as zero, and writes to them change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_PINS | Interrupt request lines |
| cfg_wr_en | input | 1 | Write strobe for a redirection entry half |
| cfg_idx | input | IDX_W | Entry index for read and write |
| cfg_hi | input | 1 | 1 selects entry bits 63:32, 0 selects bits 31:0 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected half, combinational |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
The bench targets the level-pin lock. A design that forgot to set remote-pending would flood the output with repeats of one vector. A design that cleared the lock on any end-of-interrupt would redeliver after a non-matching vector.

It holds the output stalled while several pins become pending, and while a level line rises and falls. A design that scans in the wrong order, drops a queued edge, or remembers the short level pulse shows up as a mismatch or an extra message.

Further cases are steering line 0 onto pin 2, a masked edge later unmasked, writes that try to set the read-only flag, and out-of-range indices. Each case catches a block that latches what it should drop, or lets the write port corrupt delivery state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int LEGACY_LINE = 0;
    localparam int LEGACY_PIN  = 2;

    localparam logic [31:0] MSG_BASE   = 32'hFEE0_0000;
    localparam int          DEST_SHIFT = 4;
    localparam int          DMODE_BIT  = 2;

    // bits that a write may set; remote-pending and reserved bits excluded
    localparam logic [63:0] WRITABLE = 64'hFFFF_0000_0001_AFFF;

    typedef struct packed {
        logic [15:0] dest;
        logic [30:0] rsvd_hi;
        logic        mask;
        logic        level;
        logic        remote;
        logic        polarity;
        logic        rsvd12;
        logic        dmode;
        logic [2:0]  deliv;
        logic [7:0]  vector;
    } redir_entry_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } route_msg_t;

    function automatic redir_entry_t merge_write(redir_entry_t old_e, logic hi,
                                                 logic [31:0] wd);
        logic [63:0] raw;
        redir_entry_t res;
        raw = old_e;
        if (hi) raw[63:32] = wd;
        else    raw[31:0]  = wd;
        res = redir_entry_t'(raw & WRITABLE);
        res.remote = old_e.remote & res.level;
        return res;
    endfunction

    function automatic route_msg_t format_msg(redir_entry_t e);
        route_msg_t m;
        m.addr = MSG_BASE | (32'(e.dest) << DEST_SHIFT) | (32'(e.dmode) << DMODE_BIT);
        m.data = 32'(e.vector) | (32'(e.deliv) << 8) | (32'(e.level) << 15);
        return m;
    endfunction

endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    idx,
    input  logic                                hi,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         rdata,
    input  logic                                eoi_valid,
    input  logic [7:0]                          eoi_vector,
    input  logic [NUM_PINS-1:0]                 issue,
    output redir_entry_t [NUM_PINS-1:0]         ents
);

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (idx == IDX_W'(p)) begin
                rdata = hi ? ents[p][63:32] : ents[p][31:0];
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
        logic         hit;
        logic         eoi_match;
        redir_entry_t nxt;

        assign hit       = wr_en && (idx == IDX_W'(p));
        assign eoi_match = eoi_valid && ents[p].remote && (ents[p].vector == eoi_vector);

        always_comb begin
            nxt = ents[p];
            if (hit) nxt = merge_write(ents[p], hi, wdata);
            if (eoi_match) nxt.remote = 1'b0;
            if (issue[p] && nxt.level) nxt.remote = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) ents[p] <= '0;
            else     ents[p] <= nxt;
        end

        assert_remote_by_issue_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(ents[p].remote) |-> $past(issue[p]));

        assert_remote_clear_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(ents[p].remote) |->
                $past(eoi_valid && eoi_vector == ents[p].vector) ||
                $past(wr_en && idx == IDX_W'(p)));
    end

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lines,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] issue,
    output logic [NUM_PINS-1:0] pend
);

    logic [NUM_PINS-1:0] req;
    logic [NUM_PINS-1:0] req_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (p == LEGACY_PIN) begin : g_steer
            assign req[p] = lines[p] | lines[LEGACY_LINE];
        end else if (p == LEGACY_LINE) begin : g_dead
            assign req[p] = 1'b0;
        end else begin : g_direct
            assign req[p] = lines[p];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[p] <= 1'b0;
                pend[p]  <= 1'b0;
            end else begin
                req_q[p] <= req[p];
                if (level[p]) pend[p] <= req[p];
                else          pend[p] <= (pend[p] & ~issue[p]) |
                                         (req[p] & ~req_q[p] & ~mask[p]);
            end
        end

        assert_masked_edge_drop_R4: assert property (@(posedge clk) disable iff (rst)
            ($rose(pend[p]) && $past(!level[p])) |-> $past(!mask[p]));
    end

endmodule

// File: rtl/irq_msg_issuer.sv
module irq_msg_issuer
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  redir_entry_t [NUM_PINS-1:0] ents,
    input  logic [NUM_PINS-1:0]         pend,
    input  logic                        ready,
    output logic                        valid,
    output route_msg_t                  msg,
    output logic [NUM_PINS-1:0]         issue
);

    localparam int SEL_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] elig;
    logic                found;
    logic [SEL_W-1:0]    sel;
    logic                load;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_elig
        assign elig[p] = pend[p] && !ents[p].mask && !(ents[p].level && ents[p].remote);
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (!found && elig[p]) begin
                found = 1'b1;
                sel   = SEL_W'(p);
            end
        end
    end

    assign load  = found && (!valid || ready);
    assign issue = load ? (NUM_PINS'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            msg   <= format_msg(ents[sel]);
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(msg)));

    assert_single_issue_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue));

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_lines,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_hi,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data
);

    redir_entry_t [NUM_PINS-1:0] ents;
    logic [NUM_PINS-1:0]         pend;
    logic [NUM_PINS-1:0]         issue;
    logic [NUM_PINS-1:0]         level_v;
    logic [NUM_PINS-1:0]         mask_v;
    route_msg_t                  msg;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_split
        assign level_v[p] = ents[p].level;
        assign mask_v[p]  = ents[p].mask;
    end

    irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .idx        (cfg_idx),
        .hi         (cfg_hi),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .issue      (issue),
        .ents       (ents)
    );

    irq_pend_tracker #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_lines),
        .level (level_v),
        .mask  (mask_v),
        .issue (issue),
        .pend  (pend)
    );

    irq_msg_issuer #(.NUM_PINS(NUM_PINS)) u_issue (
        .clk   (clk),
        .rst   (rst),
        .ents  (ents),
        .pend  (pend),
        .ready (msg_ready),
        .valid (msg_valid),
        .msg   (msg),
        .issue (issue)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;

endmodule

// File: tb/irq_route_engine_test.sv
module irq_route_engine_test;

    localparam int  NP     = 24;
    localparam int  IW     = 5;
    localparam time PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] irq_lines = '0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_hi = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int fails  = 0;
    int rx_cnt = 0;
    bit done   = 0;
    logic [63:0] exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    irq_route_engine #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: a transfer happens at the posedge following this sample
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && msg_valid && msg_ready) begin
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected message", {msg_addr, msg_data}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check({msg_addr, msg_data} == e, "R9 message", {msg_addr, msg_data}, e);
                end
            end
        end
    end

    function automatic logic [63:0] exp_msg(logic [7:0] vec, logic [2:0] dm, logic dmode,
                                            logic lvl, logic [15:0] dest);
        logic [31:0] a;
        logic [31:0] d;
        a = 32'hFEE0_0000 | ({16'h0, dest} << 4) | ({31'h0, dmode} << 2);
        d = {24'h0, vec} | ({29'h0, dm} << 8) | ({31'h0, lvl} << 15);
        return {a, d};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(int idx, logic hi, logic [31:0] d);
        tick(1);
        cfg_wr_en = 1'b1; cfg_idx = IW'(idx); cfg_hi = hi; cfg_wdata = d;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(int idx, logic hi, output logic [31:0] d);
        tick(1);
        cfg_idx = IW'(idx); cfg_hi = hi;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] low_word(logic [7:0] vec, logic [2:0] dm, logic dmode,
                                             logic lvl, logic msk);
        return {15'h0, msk, lvl, 1'b0, 1'b0, 1'b0, dmode, dm, vec};
    endfunction

    task automatic set_entry(int idx, logic [7:0] vec, logic [2:0] dm, logic dmode,
                             logic lvl, logic msk, logic [15:0] dest);
        cfg_write(idx, 1'b1, {dest, 16'h0});
        cfg_write(idx, 1'b0, low_word(vec, dm, dmode, lvl, msk));
    endtask

    task automatic pulse(logic [NP-1:0] m);
        tick(1);
        irq_lines = irq_lines | m;
        tick(3);
        irq_lines = irq_lines & ~m;
    endtask

    task automatic send_eoi(logic [7:0] v);
        tick(1);
        eoi_valid = 1'b1; eoi_vector = v;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", rx_cnt);
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] hold_a;
        logic [31:0] hold_d;
        int base;
        bit all_zero;

        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        check(msg_valid == 1'b0, "R1 valid after reset", 64'(msg_valid), 64'h0);
        all_zero = 1;
        for (int i = 0; i < NP; i++) begin
            cfg_read(i, 1'b0, rd); if (rd != 0) all_zero = 0;
            cfg_read(i, 1'b1, rd); if (rd != 0) all_zero = 0;
        end
        check(all_zero, "R1 entries zero", 64'(all_zero), 64'h1);

        // R9 / R6: edge pin, one message per rising request
        set_entry(5, 8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 16'hABCD);
        base = rx_cnt;
        exp_q.push_back(exp_msg(8'h41, 3'd1, 1'b1, 1'b0, 16'hABCD));
        pulse(24'h000020);
        tick(10);
        exp_q.push_back(exp_msg(8'h41, 3'd1, 1'b1, 1'b0, 16'hABCD));
        pulse(24'h000020);
        tick(10);
        check(rx_cnt - base == 2, "R6 edge count", 64'(rx_cnt - base), 64'd2);

        // R2: legacy line 0 goes through pin 2's entry
        set_entry(2, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0001);
        set_entry(0, 8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002);
        base = rx_cnt;
        exp_q.push_back(exp_msg(8'h22, 3'd0, 1'b0, 1'b0, 16'h0001));
        pulse(24'h000001);
        tick(10);
        check(rx_cnt - base == 1, "R2 single message from line 0", 64'(rx_cnt - base), 64'd1);

        // R4: masked edge dropped, unmask sends nothing
        set_entry(7, 8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0003);
        base = rx_cnt;
        pulse(24'h000080);
        tick(4);
        cfg_write(7, 1'b0, low_word(8'h77, 3'd0, 1'b0, 1'b0, 1'b0));
        tick(10);
        check(rx_cnt == base, "R4 masked edge dropped", 64'(rx_cnt - base), 64'd0);

        // R7 / R8: level pin locked by remote-pending
        set_entry(9, 8'h59, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0010);
        base = rx_cnt;
        exp_q.push_back(exp_msg(8'h59, 3'd2, 1'b0, 1'b1, 16'h0010));
        tick(1);
        irq_lines[9] = 1'b1;
        tick(12);
        check(rx_cnt - base == 1, "R7 no repeat while locked", 64'(rx_cnt - base), 64'd1);
        cfg_read(9, 1'b0, rd);
        check(rd[14] == 1'b1, "R7 remote set", 64'(rd[14]), 64'h1);
        send_eoi(8'h58);
        tick(8);
        cfg_read(9, 1'b0, rd);
        check(rd[14] == 1'b1 && rx_cnt - base == 1, "R8 wrong vector ignored",
              64'(rd[14]), 64'h1);
        exp_q.push_back(exp_msg(8'h59, 3'd2, 1'b0, 1'b1, 16'h0010));
        send_eoi(8'h59);
        tick(8);
        check(rx_cnt - base == 2, "R8 redelivery after match", 64'(rx_cnt - base), 64'd2);
        irq_lines[9] = 1'b0;
        send_eoi(8'h59);
        tick(8);
        cfg_read(9, 1'b0, rd);
        check(rd[14] == 1'b0 && rx_cnt - base == 2, "R8 clear with line low",
              64'(rd[14]), 64'h0);

        // R10 / R3 / R5: stall, short level pulse, ascending order
        set_entry(3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0033);
        set_entry(12, 8'h3C, 3'd0, 1'b0, 1'b0, 1'b0, 16'h003C);
        set_entry(11, 8'h6B, 3'd0, 1'b0, 1'b1, 1'b0, 16'h006B);
        tick(1);
        msg_ready = 1'b0;
        exp_q.push_back(exp_msg(8'h41, 3'd1, 1'b1, 1'b0, 16'hABCD));
        exp_q.push_back(exp_msg(8'h33, 3'd0, 1'b0, 1'b0, 16'h0033));
        exp_q.push_back(exp_msg(8'h3C, 3'd0, 1'b0, 1'b0, 16'h003C));
        pulse(24'h000020);
        tick(2);
        hold_a = msg_addr; hold_d = msg_data;
        pulse(24'h001008);
        irq_lines[11] = 1'b1;
        tick(3);
        irq_lines[11] = 1'b0;
        tick(3);
        check(msg_valid && msg_addr == hold_a && msg_data == hold_d, "R10 hold while stalled",
              {msg_addr, msg_data}, {hold_a, hold_d});
        base = rx_cnt;
        msg_ready = 1'b1;
        tick(12);
        check(rx_cnt - base == 3, "R3/R5 stalled drain count", 64'(rx_cnt - base), 64'd3);

        // R5: simultaneous requests with ready high
        set_entry(4, 8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0044);
        set_entry(20, 8'h94, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0094);
        exp_q.push_back(exp_msg(8'h44, 3'd0, 1'b0, 1'b0, 16'h0044));
        exp_q.push_back(exp_msg(8'h94, 3'd0, 1'b0, 1'b0, 16'h0094));
        pulse(24'h100010);
        tick(10);

        // R11: unmask by rewrite delivers, remote read-only, edge rewrite clears it
        set_entry(14, 8'h4E, 3'd0, 1'b0, 1'b1, 1'b1, 16'h004E);
        base = rx_cnt;
        tick(1);
        irq_lines[14] = 1'b1;
        tick(8);
        check(rx_cnt == base, "R11 masked level held", 64'(rx_cnt - base), 64'd0);
        exp_q.push_back(exp_msg(8'h4E, 3'd0, 1'b0, 1'b1, 16'h004E));
        cfg_write(14, 1'b0, low_word(8'h4E, 3'd0, 1'b0, 1'b1, 1'b0));
        tick(8);
        check(rx_cnt - base == 1, "R11 unmask delivers", 64'(rx_cnt - base), 64'd1);
        cfg_write(16, 1'b0, low_word(8'h60, 3'd0, 1'b0, 1'b1, 1'b1) | 32'h0000_5000);
        cfg_read(16, 1'b0, rd);
        check(rd[14] == 1'b0 && rd[12] == 1'b0, "R11 read-only and reserved bits",
              64'(rd), 64'(low_word(8'h60, 3'd0, 1'b0, 1'b1, 1'b1)));
        cfg_write(14, 1'b0, low_word(8'h4E, 3'd0, 1'b0, 1'b0, 1'b1));
        cfg_read(14, 1'b0, rd);
        check(rd[14] == 1'b0, "R11 edge rewrite clears remote", 64'(rd[14]), 64'h0);
        irq_lines[14] = 1'b0;

        // R12: out-of-range index
        cfg_write(25, 1'b0, 32'hFFFF_FFFF);
        cfg_write(25, 1'b1, 32'hFFFF_FFFF);
        cfg_read(25, 1'b0, rd);
        check(rd == 32'h0, "R12 out-of-range reads zero", 64'(rd), 64'h0);
        cfg_read(0, 1'b0, rd);
        check(rd == low_word(8'h30, 3'd0, 1'b0, 1'b0, 1'b0), "R12 entry 0 untouched",
              64'(rd), 64'(low_word(8'h30, 3'd0, 1'b0, 1'b0, 1'b0)));

        tick(10);
        check(exp_q.size() == 0, "R6 all expected messages seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule